// File: doc/BRIEF.md
# Prioritized Interrupt Latch Controller

A vectored interrupt front end for a small 8-bit CPU. Each interrupt source has a pending latch, and a one-cycle request pulse sets it. Two non-maskable latches, at indices 2 and 3, hold the address-trap and watchdog requests. Twelve maskable levels, at indices 4 to 15, each pass only when the global master enable and the level's own enable are both set. Level 4 also needs an external-pin enable. Levels 9, 14 and 15 can each take their request from one of two sources, and a select bit per level picks which one.

The controller picks a winner combinationally. Any pending non-maskable latch wins over every maskable one. Among the maskable levels, the lowest index wins. The controller presents the winner as `irq_o` together with a fixed 16-bit vector. When the CPU pulses `ack_i`, the controller clears the latch that was being presented in that cycle. If that latch was maskable, it also clears the master enable, so software must set it again before a nested maskable interrupt can be taken.

Software uses a byte-wide register port. It writes zeros to clear latches, and it sets the enables and select bits through the same port.

Top module: `prio_irq_latch_ctrl`

## Requirements
- R1: After reset, all of the following are 0: all latches, all enables, the master enable, the external-pin enable and all select bits. Also after reset, `irq_o` is 0, `vec_o` is 0, and every register reads 0.
- R2: A request pulse sets its latch on the next edge. `nmi_req_i[0]` sets latch 2 and `nmi_req_i[1]` sets latch 3. Level n (4..15) maps to bit n-4 of `lvl_req_i`. Latches 0..7 read at address 0x3C bit n, and latches 8..15 read at 0x3D bit n-8. Bits 0 and 1 of 0x3C always read 0.
- R3: A write to 0x3C or 0x3D clears each latch whose data bit is 0 and leaves alone each latch whose data bit is 1. A request arriving in the same cycle as a clear wins, and the latch stays set.
- R4: A maskable level n is eligible only when its latch is set, the master enable is set and its enable is set. The master enable is bit 0 of 0x3A. The enables for levels 4..7 are bits 4..7 of 0x3A, and those for levels 8..15 are bits 0..7 of 0x3B. Bits 1..3 of 0x3A read 0.
- R5: Level 4 is additionally eligible only when the external-pin enable (0x38 bit 0) is 1.
- R6: Levels 9, 14 and 15 use the select bits at 0x38 bits 1, 2 and 3 respectively. A select bit of 0 takes the level's `lvl_req_i` bit, and 1 takes its `alt_req_i` bit. The source that is not selected is ignored. On every other level, `alt_req_i` is ignored. Bits 7..4 of 0x38 read 0.
- R7: While a winner n exists, `irq_o` is 1 and `vec_o` = 0xFFFE - 2n. Otherwise both outputs are 0.
- R8: A set non-maskable latch wins regardless of any enable and ahead of every maskable level. Latch 2 is chosen before latch 3.
- R9: Among eligible maskable levels, the lowest index wins.
- R10: `ack_i` with `irq_o` = 1 clears exactly the presented latch. If a request for that same latch arrives in the same cycle, the latch stays set. `ack_i` with `irq_o` = 0 has no effect.
- R11: Accepting a maskable winner clears the master enable, and this takes precedence over a write in the same cycle. Accepting a non-maskable winner leaves the master enable unchanged.
- R12: Writes to addresses other than 0x38, 0x3A, 0x3B, 0x3C and 0x3D change nothing, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_req_i | input | 2 | Non-maskable request pulses (latches 2, 3) |
| lvl_req_i | input | 12 | Primary maskable request pulses, levels 4..15 |
| alt_req_i | input | 12 | Second-source request pulses, used on multiplexed levels |
| ack_i | input | 1 | CPU accept pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt pending toward the CPU |
| vec_o | output | 16 | Vector address of the current winner |

## Verification
The bench uses the default parameters: two non-maskable latches, twelve maskable levels, and multiplexing on levels 9, 14 and 15 at register base 0x38. With these values, all sixteen latch positions are reached, and so are both register bytes for latches and for enables. The gated level 4 and all three select paths are also reached. Together, these bring the non-maskable precedence into reach, along with the full descending vector range from 0xFFFA down to 0xFFE0. Random traffic also produces the same-cycle collisions that matter: set against zero-write, set against accept, and accept against a master-enable write.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int unsigned VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFE;

  function automatic logic [VEC_W-1:0] vec_of(input logic [3:0] idx);
    return VEC_TOP - VEC_W'({idx, 1'b0});
  endfunction

  // number of set bits of mask strictly below pos
  function automatic int unsigned rank_below(input logic [31:0] mask, input int unsigned pos);
    int unsigned c;
    c = 0;
    for (int unsigned b = 0; b < 32; b++)
      if (b < pos && mask[b]) c++;
    return c;
  endfunction

  function automatic int unsigned count_ones(input logic [31:0] mask);
    return rank_below(mask, 32);
  endfunction
endpackage

// File: rtl/pil_src_mux.sv
module pil_src_mux #(
  parameter int unsigned N_LVL = 12,
  parameter logic [N_LVL-1:0] MUX_LVL = 12'b1100_0010_0000,
  parameter int unsigned N_MUX = 3
) (
  input  logic [N_LVL-1:0] pri_i,
  input  logic [N_LVL-1:0] alt_i,
  input  logic [N_MUX-1:0] sel_i,
  output logic [N_LVL-1:0] req_o
);
  for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
    if (MUX_LVL[k]) begin : g_mux
      localparam int unsigned RK = pil_pkg::rank_below(32'(MUX_LVL), k);
      assign req_o[k] = sel_i[RK] ? alt_i[k] : pri_i[k];
    end else begin : g_pass
      assign req_o[k] = pri_i[k] | (alt_i[k] & 1'b0);
    end
  end
endmodule

// File: rtl/pil_latch_bank.sv
module pil_latch_bank #(
  parameter int unsigned N_LAT = 16,
  parameter int unsigned FIRST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LAT-1:0] set_i,
  input  logic [N_LAT-1:0] wclr_i,
  input  logic [N_LAT-1:0] aclr_i,
  output logic [N_LAT-1:0] lat_o
);
  for (genvar i = 0; i < N_LAT; i++) begin : g_bit
    if (i < FIRST) begin : g_rsvd
      assign lat_o[i] = 1'b0;
    end else begin : g_lat
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= set_i[i] | (q & ~wclr_i[i] & ~aclr_i[i]); // set wins
      end
      assign lat_o[i] = q;
    end
  end
endmodule

// File: rtl/pil_regs.sv
module pil_regs #(
  parameter int unsigned N_LAT = 16,
  parameter int unsigned LVL0 = 4,
  parameter int unsigned CTRL_W = 4,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h38
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [N_LAT-1:0]  lat_i,
  input  logic              take_mask_i,
  output logic [N_LAT-1:0]  en_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [7:0]        rd_data_o,
  output logic [N_LAT-1:0]  wclr_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE;
  localparam logic [ADDR_W-1:0] A_ENL  = BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ENH  = BASE + ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ILL  = BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ILH  = BASE + ADDR_W'(5);
  // bit 0 is the master enable, bits below LVL0 otherwise reserved
  localparam logic [N_LAT-1:0] EN_MASK = ({N_LAT{1'b1}} << LVL0) | N_LAT'(1);

  logic [N_LAT-1:0]  en_q, en_d;
  logic [CTRL_W-1:0] ctrl_q;

  always_comb begin
    en_d = en_q;
    if (wr_en_i && wr_addr_i == A_ENL) en_d[7:0]  = wr_data_i & EN_MASK[7:0];
    if (wr_en_i && wr_addr_i == A_ENH) en_d[15:8] = wr_data_i & EN_MASK[15:8];
    if (take_mask_i) en_d[0] = 1'b0; // accept beats write
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else begin
      en_q <= en_d;
      if (wr_en_i && wr_addr_i == A_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    wclr_o = '0;
    if (wr_en_i && wr_addr_i == A_ILL) wclr_o[7:0]  = ~wr_data_i;
    if (wr_en_i && wr_addr_i == A_ILH) wclr_o[15:8] = ~wr_data_i;
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = 8'(ctrl_q);
      A_ENL:   rd_data_o = en_q[7:0];
      A_ENH:   rd_data_o = en_q[15:8];
      A_ILL:   rd_data_o = lat_i[7:0];
      A_ILH:   rd_data_o = lat_i[15:8];
      default: rd_data_o = 8'h00;
    endcase
  end

  assign en_o   = en_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pil_arb.sv
module pil_arb #(
  parameter int unsigned N_LAT = 16,
  parameter int unsigned IDX_W = 4,
  parameter logic [N_LAT-1:0] NMI_MASK = 16'h000C,
  parameter logic [N_LAT-1:0] LVL_MASK = 16'hFFF0
) (
  input  logic [N_LAT-1:0] lat_i,
  input  logic [N_LAT-1:0] gate_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [15:0]      vec_o
);
  logic [N_LAT-1:0] nmi_hit, msk_hit, cand;

  assign nmi_hit = lat_i & NMI_MASK;
  assign msk_hit = lat_i & gate_i & LVL_MASK;
  // non-maskable group first; lowest index picked inside a group
  assign cand    = (|nmi_hit) ? nmi_hit : msk_hit;

  always_comb begin
    idx_o = '0;
    for (int i = N_LAT - 1; i >= 0; i--)
      if (cand[i]) idx_o = IDX_W'(i);
  end

  assign irq_o = |cand;
  assign vec_o = irq_o ? pil_pkg::vec_of(4'(idx_o)) : 16'h0000;
endmodule

// File: rtl/prio_irq_latch_ctrl.sv
module prio_irq_latch_ctrl #(
  parameter int unsigned N_NMI = 2,
  parameter int unsigned N_LVL = 12,
  parameter logic [N_LVL-1:0] MUX_LVL = 12'b1100_0010_0000,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 8'h38
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_NMI-1:0]  nmi_req_i,
  input  logic [N_LVL-1:0]  lvl_req_i,
  input  logic [N_LVL-1:0]  alt_req_i,
  input  logic              ack_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_o,
  output logic [15:0]       vec_o
);
  localparam int unsigned FIRST  = 2;
  localparam int unsigned LVL0   = FIRST + N_NMI;
  localparam int unsigned N_LAT  = LVL0 + N_LVL; // register map assumes 16
  localparam int unsigned IDX_W  = $clog2(N_LAT);
  localparam int unsigned N_MUX  = pil_pkg::count_ones(32'(MUX_LVL));
  localparam int unsigned CTRL_W = 1 + N_MUX;
  localparam logic [N_LAT-1:0] NMI_MASK = N_LAT'(((1 << N_NMI) - 1) << FIRST);
  localparam logic [N_LAT-1:0] LVL_MASK = {N_LAT{1'b1}} << LVL0;

  logic [N_LAT-1:0]  lat_q, set_v, wclr_v, aclr_v, gate_v, en_vec;
  logic [CTRL_W-1:0] ctrl_v;
  logic [N_LVL-1:0]  lvl_set;
  logic [IDX_W-1:0]  win_idx;
  logic              take, take_mask;

  pil_src_mux #(.N_LVL(N_LVL), .MUX_LVL(MUX_LVL), .N_MUX(N_MUX)) u_mux (
    .pri_i(lvl_req_i), .alt_i(alt_req_i), .sel_i(ctrl_v[CTRL_W-1:1]), .req_o(lvl_set)
  );

  always_comb begin
    set_v = '0;
    set_v[FIRST +: N_NMI] = nmi_req_i;
    set_v[LVL0 +: N_LVL]  = lvl_set;
  end

  // eligibility: master enable, own enable, level 0 also needs the pin enable
  for (genvar i = 0; i < N_LAT; i++) begin : g_gate
    if (i < LVL0) begin : g_ng
      assign gate_v[i] = 1'b0;
    end else if (i == LVL0) begin : g_pin
      assign gate_v[i] = en_vec[0] & en_vec[i] & ctrl_v[0];
    end else begin : g_std
      assign gate_v[i] = en_vec[0] & en_vec[i];
    end
  end

  pil_arb #(.N_LAT(N_LAT), .IDX_W(IDX_W), .NMI_MASK(NMI_MASK), .LVL_MASK(LVL_MASK)) u_arb (
    .lat_i(lat_q), .gate_i(gate_v), .irq_o(irq_o), .idx_o(win_idx), .vec_o(vec_o)
  );

  assign take      = ack_i & irq_o;
  assign take_mask = take & (win_idx >= IDX_W'(LVL0));
  assign aclr_v    = take ? (N_LAT'(1) << win_idx) : '0;

  pil_regs #(.N_LAT(N_LAT), .LVL0(LVL0), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .BASE(REG_BASE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .lat_i(lat_q), .take_mask_i(take_mask),
    .en_o(en_vec), .ctrl_o(ctrl_v), .rd_data_o(rd_data_o), .wclr_o(wclr_v)
  );

  pil_latch_bank #(.N_LAT(N_LAT), .FIRST(FIRST)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .wclr_i(wclr_v), .aclr_i(aclr_v), .lat_o(lat_q)
  );
endmodule

// File: rtl/prio_irq_latch_ctrl_chk.sv
module prio_irq_latch_ctrl_chk #(
  parameter int unsigned N_NMI = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_NMI-1:0] nmi_req_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [15:0]      vec_o,
  input logic [15:0]      lat_i,
  input logic             imf_i
);
  p_vec_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == 16'h0000);

  p_set_nmi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_i[1] |=> lat_i[3]);

  p_nmi_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_i[2] |-> (irq_o && vec_o == 16'hFFFA));

  p_mask_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !lat_i[2] && !lat_i[3]) |-> imf_i);

  p_ack_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && vec_o == 16'hFFFA && !nmi_req_i[0]) |=> !lat_i[2]);

  p_imf_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && vec_o < 16'hFFF8) |=> !imf_i);
endmodule

bind prio_irq_latch_ctrl prio_irq_latch_ctrl_chk #(.N_NMI(N_NMI)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .nmi_req_i(nmi_req_i), .ack_i(ack_i),
  .irq_o(irq_o), .vec_o(vec_o), .lat_i(lat_q), .imf_i(en_vec[0])
);

// File: tb/prio_irq_latch_ctrl_tb_top.sv
module prio_irq_latch_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [1:0]  nmi_req;
  logic [11:0] lvl_req, alt_req;
  logic        ack, wr_en;
  logic [7:0]  wr_addr, wr_data, rd_addr, rd_data;
  logic        irq;
  logic [15:0] vec;

  prio_irq_latch_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nmi_req_i(nmi_req), .lvl_req_i(lvl_req),
    .alt_req_i(alt_req), .ack_i(ack), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .vec_o(vec)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  logic [15:0] m_lat = '0, m_en = '0;
  logic [3:0]  m_ctrl = '0;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h @%0t", t, act, exp, $time);
    end
  endtask

  function automatic int m_win();
    for (int n = 2; n < 4; n++) if (m_lat[n]) return n;
    for (int n = 4; n < 16; n++)
      if (m_lat[n] && m_en[0] && m_en[n] && (n != 4 || m_ctrl[0])) return n;
    return -1;
  endfunction

  function automatic logic [7:0] m_rd(input logic [7:0] a);
    case (a)
      8'h38: return {4'h0, m_ctrl};
      8'h3A: return m_en[7:0];
      8'h3B: return m_en[15:8];
      8'h3C: return m_lat[7:0];
      8'h3D: return m_lat[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic zero_in();
    nmi_req = '0; lvl_req = '0; alt_req = '0; ack = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  // inputs already driven after a falling edge; compare, clock, update model
  task automatic step();
    int w;
    logic [15:0] set_v, wclr, aclr;
    logic take_m, src;
    #1;
    w = m_win();
    chk({tag, " irq"}, 32'(irq), 32'(w >= 0));
    chk({tag, " vec"}, 32'(vec), (w >= 0) ? 32'(16'hFFFE - 16'(2 * w)) : 32'h0);
    chk({tag, " rd"}, 32'(rd_data), 32'(m_rd(rd_addr)));
    @(posedge clk);
    set_v = '0;
    set_v[2] = nmi_req[0];
    set_v[3] = nmi_req[1];
    for (int k = 0; k < 12; k++) begin
      src = lvl_req[k];
      if (k == 5  && m_ctrl[1]) src = alt_req[k];
      if (k == 10 && m_ctrl[2]) src = alt_req[k];
      if (k == 11 && m_ctrl[3]) src = alt_req[k];
      set_v[k + 4] = src;
    end
    wclr = '0;
    if (wr_en && wr_addr == 8'h3C) wclr[7:0]  = ~wr_data;
    if (wr_en && wr_addr == 8'h3D) wclr[15:8] = ~wr_data;
    aclr = (ack && w >= 0) ? (16'h1 << w) : '0;
    take_m = ack && w >= 4;
    m_lat = ((m_lat & ~wclr & ~aclr) | set_v) & 16'hFFFC;
    if (wr_en) begin
      case (wr_addr)
        8'h38: m_ctrl = wr_data[3:0];
        8'h3A: m_en[7:0] = wr_data & 8'hF1;
        8'h3B: m_en[15:8] = wr_data;
        default: ;
      endcase
    end
    if (take_m) m_en[0] = 1'b0;
    @(negedge clk);
    zero_in();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [6];
    addrs = '{8'h38, 8'h3A, 8'h3B, 8'h3C, 8'h3D, 8'h39};
    void'($urandom(32'd1357));
    rst_n = 1'b0; rd_addr = 8'h3C;
    zero_in();
    repeat (3) @(negedge clk);
    // R1: reset state on every register
    foreach (addrs[i]) begin
      rd_addr = addrs[i]; #1;
      chk("R1 rd", 32'(rd_data), 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 vec", 32'(vec), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R2"; rd_addr = 8'h3C; nmi_req = 2'b10; step(); step();
    tag = "R3"; wr(8'h3C, 8'hF7); step(); step();
    tag = "R3 set-wins"; nmi_req = 2'b01; wr(8'h3C, 8'h00); step(); step();
    tag = "R10 nmi-ack"; ack = 1'b1; step(); step();
    tag = "R4"; rd_addr = 8'h3A; lvl_req[3] = 1'b1; step(); step();
    wr(8'h3A, 8'hFF); step(); step();
    tag = "R5"; lvl_req[0] = 1'b1; step(); step();
    wr(8'h38, 8'h01); rd_addr = 8'h38; step(); step();
    tag = "R11"; ack = 1'b1; step(); step();
    tag = "R10 idle-ack"; rd_addr = 8'h3D; wr(8'h3C, 8'h00); step(); ack = 1'b1; step(); step();
    tag = "R6"; wr(8'h38, 8'hFF); step(); wr(8'h3B, 8'hFF); step();
    wr(8'h3A, 8'h01); step();
    lvl_req[5] = 1'b1; lvl_req[11] = 1'b1; step(); step();
    alt_req[5] = 1'b1; alt_req[1] = 1'b1; step(); step();
    tag = "R9"; lvl_req[8] = 1'b1; step(); ack = 1'b1; step(); step();
    tag = "R8"; wr(8'h3A, 8'h01); nmi_req = 2'b11; step(); ack = 1'b1; step(); ack = 1'b1; step(); step();
    tag = "R12"; wr(8'h39, 8'hFF); rd_addr = 8'h39; step(); wr(8'h3E, 8'h00); rd_addr = 8'h3D; step(); step();
    tag = "R7"; wr(8'h3C, 8'h00); step(); wr(8'h3D, 8'h00); step(); step();

    tag = "R7 R8 R9 R10 R11 rand";
    for (int c = 0; c < 4000; c++) begin
      nmi_req = 2'(($urandom % 12 == 0) ? $urandom : 0);
      lvl_req = 12'($urandom & $urandom & $urandom & $urandom);
      alt_req = 12'($urandom & $urandom & $urandom);
      ack     = ($urandom % 3 == 0);
      if ($urandom % 5 == 0) begin
        wr_en   = 1'b1;
        wr_addr = ($urandom % 8 == 0) ? 8'($urandom) : addrs[$urandom % 5];
        wr_data = 8'($urandom);
        if (wr_addr == 8'h3A && ($urandom % 2 == 0)) wr_data[0] = 1'b1;
      end
      rd_addr = addrs[$urandom % 6];
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule